// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single-word read and write requests from an on-chip valid/ready interface into the slow strobe sequences of an external asynchronous static RAM. The RAM has an 18-bit word address, a 16-bit data bus, one active-low select, a write strobe, an output enable and two active-low byte-lane enables. The controller splits the bidirectional data bus into an output word, an output-enable flag and an input word, so the pad ring can build the tristate buffer.

Each strobe phase lasts a whole number of clock cycles. That number comes from a nanosecond timing window rounded up to the clock period and is never less than one cycle. A write presents the address with the select low, then pulses the write strobe and holds the bus for a recovery phase. A read keeps the select and the output enable low for the access time and then samples the bus. After a read the strobes stay released for a turnaround gap before the bus may be driven again. Every request ends with a single-cycle done pulse. For reads, that pulse carries the returned word.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever the controller is idle, mem_cs_n, mem_we_n and mem_oe_n are high, both bits of mem_be_n are high, mem_dq_oe is low and req_ready is high.
- R2: A request is taken only at a clock edge where req_valid and req_ready are both high. req_ready goes low in the next cycle and stays low until the operation has finished.
- R3: A write shows N_WS = 1 cycle with the select low and the write strobe high, then exactly N_WP = ceil(max(35, 25, 40 - clock period) ns / clock period) cycles with the write strobe low, then N_WREC = max(1, ceil(55 ns / period) - N_WS - N_WP) cycles with the write strobe high and the select still low.
- R4: mem_dq_oe is high, with mem_dq_out holding the request data, from the first write cycle up to and including the cycle in which the write strobe rises. It is never high while mem_oe_n is low.
- R5: Mask bit 0 enables lane 7:0 through mem_be_n[0], and mask bit 1 enables lane 15:8 through mem_be_n[1]. Only enabled lanes are written. With a mask of 00, mem_cs_n stays high for the whole operation, the memory contents do not change, and the request still completes.
- R6: A read holds mem_cs_n and mem_oe_n low with mem_we_n high for N_RD = ceil(max(55, 25) ns / period) cycles. The bus is sampled at the edge that ends the last of those cycles. Lanes whose mask bit is 0 return zero.
- R7: rsp_done is high for exactly one cycle. Counting the acceptance edge as edge 0, it rises after edge N_WS+N_WP+N_WREC for a write and after edge N_RD for a read. For a read, rsp_rdata is valid in that cycle.
- R8: After a read, the strobes stay released for N_TA = ceil(20 ns / period) cycles before req_ready returns. mem_dq_oe never rises within N_TA cycles of mem_oe_n going high.
- R9: mem_addr changes only at an edge where mem_cs_n was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | 18 | Address to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low lane enables, bit 0 lower, bit 1 upper |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data received from the memory |

## Verification
A corrupted phase state or phase counter appears at the pins within one strobe phase. The symptoms are a write pulse of the wrong length, an output enable held low too long or too short, a done pulse that comes early or late, or a bus drive that overlaps the output enable. A wrong latched mask or address may show nothing at the strobes at all. It only shows up when the affected word is read back, so the stimulus writes and then reads each location under every mask value. A turnaround fault shows only when a write follows a read closely, so back-to-back pairs of that kind are part of the stimulus.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int LANES = 2;
    localparam int DW    = 8 * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WREC,
        ST_RACC,
        ST_RTURN
    } phase_e;

    typedef struct packed {
        logic             cs_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] be_n;
        logic             drv;
    } strobe_t;

    localparam strobe_t STROBE_PARK = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                        be_n: {LANES{1'b1}}, drv: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles covering a window, never below one
    function automatic int cyc_ceil(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic strobe_t phase_strobes(input phase_e ph, input logic [LANES-1:0] mask);
        strobe_t s;
        logic    any;
        s   = STROBE_PARK;
        any = |mask;
        case (ph)
            ST_WSET, ST_WREC: begin
                s.cs_n = ~any;
                s.be_n = ~mask;
                s.drv  = 1'b1;
            end
            ST_WPUL: begin
                s.cs_n = ~any;
                s.we_n = ~any;
                s.be_n = ~mask;
                s.drv  = 1'b1;
            end
            ST_RACC: begin
                s.cs_n = ~any;
                s.oe_n = ~any;
                s.be_n = ~mask;
            end
            default: s = STROBE_PARK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int CW     = 4,
    parameter int N_WS   = 1,
    parameter int N_WP   = 4,
    parameter int N_WREC = 1,
    parameter int N_RD   = 6,
    parameter int N_TA   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          is_write,
    input  logic          phase_last,
    output phase_e        state_q,
    output phase_e        state_d,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          done_d,
    output logic          capture
);
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        done_d   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                load = 1'b1;
                if (is_write) begin
                    state_d  = ST_WSET;
                    load_val = CW'(N_WS - 1);
                end else begin
                    state_d  = ST_RACC;
                    load_val = CW'(N_RD - 1);
                end
            end
            ST_WSET: if (phase_last) begin
                state_d  = ST_WPUL;
                load     = 1'b1;
                load_val = CW'(N_WP - 1);
            end
            ST_WPUL: if (phase_last) begin
                state_d  = ST_WREC;
                load     = 1'b1;
                load_val = CW'(N_WREC - 1);
            end
            ST_WREC: if (phase_last) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_RACC: if (phase_last) begin
                state_d  = ST_RTURN;
                load     = 1'b1;
                load_val = CW'(N_TA - 1);
                done_d   = 1'b1;
                capture  = 1'b1;
            end
            ST_RTURN: if (phase_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R2
    idle_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> state_q == ST_IDLE);
endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [8*LANES-1:0] dq_in,
    output logic [8*LANES-1:0] rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[8*i +: 8] <= 8'h00;
            else if (capture)
                rdata[8*i +: 8] <= lane_en[i] ? dq_in[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sramc_pkg::*;
#(
    parameter int AW      = 18,
    parameter int CLK_NS  = 10,
    parameter int T_WP_NS = 35,
    parameter int T_AW_NS = 40,
    parameter int T_DW_NS = 25,
    parameter int T_WC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 25,
    parameter int T_HZ_NS = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in
);
    localparam int N_WS   = 1;
    localparam int N_WP   = cyc_ceil(imax(T_WP_NS, imax(T_DW_NS, T_AW_NS - N_WS * CLK_NS)), CLK_NS);
    localparam int N_WREC = imax(1, cyc_ceil(T_WC_NS, CLK_NS) - N_WS - N_WP);
    localparam int N_RD   = cyc_ceil(imax(T_AA_NS, T_OE_NS), CLK_NS);
    localparam int N_TA   = cyc_ceil(T_HZ_NS, CLK_NS);
    localparam int N_SUM  = N_WS + N_WP + N_WREC + N_RD + N_TA;
    localparam int CW     = $clog2(N_SUM + 1);

    phase_e            state_q, state_d;
    logic              accept, load, last, done_d, capture;
    logic [CW-1:0]     load_val;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [LANES-1:0]  be_q, be_next;
    strobe_t           strb_q;
    logic              done_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign be_next   = accept ? req_be : be_q;

    sramc_seq #(
        .CW(CW), .N_WS(N_WS), .N_WP(N_WP), .N_WREC(N_WREC), .N_RD(N_RD), .N_TA(N_TA)
    ) i_seq (
        .clk(clk), .rst(rst), .accept(accept), .is_write(req_write),
        .phase_last(last), .state_q(state_q), .state_d(state_d),
        .load(load), .load_val(load_val), .done_d(done_d), .capture(capture)
    );

    sramc_phase_timer #(.CW(CW)) i_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .last(last)
    );

    sramc_rd_capture #(.LANES(LANES)) i_capture (
        .clk(clk), .rst(rst), .capture(capture), .lane_en(be_q),
        .dq_in(mem_dq_in), .rdata(rsp_rdata)
    );

    // request latch: address only moves at acceptance, while the select is parked
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // registered strobes so the pins never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q <= STROBE_PARK;
            done_q <= 1'b0;
        end else begin
            strb_q <= phase_strobes(state_d, be_next);
            done_q <= done_d;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_cs_n   = strb_q.cs_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign mem_be_n   = strb_q.be_n;
    assign mem_dq_oe  = strb_q.drv;
    assign mem_dq_out = wdata_q;
    assign rsp_done   = done_q;

    // checker state: write pulse length and release time of the output enable
    logic [7:0] we_low_cnt, hz_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
            hz_cnt     <= 8'(N_TA);
        end else begin
            if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
            else           we_low_cnt <= '0;
            if (!mem_oe_n)                hz_cnt <= '0;
            else if (hz_cnt < 8'(N_TA))   hz_cnt <= hz_cnt + 8'd1;
        end
    end

    // R3
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> we_low_cnt == 8'(N_WP));
    // R4
    drive_over_we_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe && !mem_cs_n);
    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> hz_cnt >= 8'(N_TA));
    // R9
    addr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> $past(mem_cs_n));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
    localparam int CLK_PERIOD = 10;

    function automatic int ceil_cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int EXP_WS, EXP_WP, EXP_WREC, EXP_RD, EXP_TA;

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    int errors = 0, checks = 0;
    bit finished = 0;

    logic [15:0] mem_arr [0:1023];
    logic [15:0] ref_arr [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: drives only enabled lanes during a read, junk elsewhere
    logic rd_lo, rd_hi;
    assign rd_lo = !mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[0];
    assign rd_hi = !mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[1];
    assign mem_dq_in = {rd_hi ? mem_arr[mem_addr[9:0]][15:8] : 8'hA5,
                        rd_lo ? mem_arr[mem_addr[9:0]][7:0]  : 8'h5A};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // pin monitor, sampled at the falling edge
    logic        we_prev = 1, oe_prev = 1, drv_prev = 0, cs_prev = 1;
    logic [17:0] addr_prev = '0;
    int we_low = 0, oe_low = 0, oe_high = 100;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) we_low++;
            if (!we_prev && mem_we_n) begin
                chk(we_low == EXP_WP, "R3 write pulse length", we_low, EXP_WP);
                chk(mem_dq_oe && !mem_cs_n, "R4 bus driven at write end", {mem_dq_oe, mem_cs_n}, 2'b10);
                if (!mem_cs_n) begin
                    if (!mem_be_n[0]) mem_arr[mem_addr[9:0]][7:0]  = mem_dq_out[7:0];
                    if (!mem_be_n[1]) mem_arr[mem_addr[9:0]][15:8] = mem_dq_out[15:8];
                end
                we_low = 0;
            end
            if (!mem_oe_n) begin oe_low++; oe_high = 0; end
            else oe_high++;
            if (!oe_prev && mem_oe_n) begin
                chk(oe_low == EXP_RD, "R6 read strobe length", oe_low, EXP_RD);
                oe_low = 0;
            end
            if (mem_dq_oe && !drv_prev)
                chk(oe_high > EXP_TA, "R8 turnaround before drive", oe_high - 1, EXP_TA);
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R4 drive during output enable", 1, 0);
            if (mem_addr != addr_prev)
                chk(cs_prev, "R9 address moved with select low", cs_prev, 1);
        end
        we_prev = mem_we_n; oe_prev = mem_oe_n; drv_prev = mem_dq_oe;
        cs_prev = mem_cs_n; addr_prev = mem_addr;
    end

    task automatic chk_park(input string req);
        chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe && req_ready,
            req, {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, req_ready}, 7'b1111101);
    endtask

    task automatic run_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        int lat;
        bit cs_seen;
        logic [15:0] exp;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 ready low after accept", req_ready, 0);
        lat = 0; cs_seen = 0;
        while (!rsp_done && lat < 100) begin
            if (!mem_cs_n) cs_seen = 1;
            @(negedge clk);
            lat++;
        end
        chk(lat == (wr ? EXP_WS + EXP_WP + EXP_WREC : EXP_RD), "R7 done latency",
            lat, wr ? EXP_WS + EXP_WP + EXP_WREC : EXP_RD);
        if (be == 2'b00) chk(!cs_seen, "R5 empty mask keeps select high", cs_seen, 0);
        if (wr) begin
            if (be[0]) ref_arr[a[9:0]][7:0]  = d[7:0];
            if (be[1]) ref_arr[a[9:0]][15:8] = d[15:8];
            chk_park("R1 parked after write");
        end else begin
            exp = {be[1] ? ref_arr[a[9:0]][15:8] : 8'h00, be[0] ? ref_arr[a[9:0]][7:0] : 8'h00};
            chk(rsp_rdata == exp, "R6 R5 read data per lane", rsp_rdata, exp);
            chk(!req_ready, "R8 ready held during turnaround", req_ready, 0);
            repeat (EXP_TA - 1) @(negedge clk);
            chk(!req_ready, "R8 ready before gap ends", req_ready, 0);
            @(negedge clk);
            chk_park("R1 R8 parked after turnaround");
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        EXP_WS   = 1;
        EXP_WP   = ceil_cyc(mx(35, mx(25, 40 - CLK_PERIOD)));
        EXP_WREC = mx(1, ceil_cyc(55) - EXP_WS - EXP_WP);
        EXP_RD   = ceil_cyc(mx(55, 25));
        EXP_TA   = ceil_cyc(20);
        for (int i = 0; i < 1024; i++) begin mem_arr[i] = 16'h0000; ref_arr[i] = 16'h0000; end
        void'($urandom(32'd2468));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_park("R1 reset state");
        chk(!rsp_done, "R7 no done after reset", rsp_done, 0);

        // directed corners
        run_op(1, 18'h3FFFF, 16'hBEEF, 2'b11);
        run_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        run_op(1, 18'h00005, 16'hAAAA, 2'b11);
        run_op(1, 18'h00005, 16'h1234, 2'b01);
        run_op(0, 18'h00005, 16'h0000, 2'b11);
        run_op(0, 18'h00005, 16'h0000, 2'b10);
        run_op(1, 18'h00005, 16'hFFFF, 2'b00);
        run_op(0, 18'h00005, 16'h0000, 2'b11);
        run_op(0, 18'h00005, 16'h0000, 2'b00);
        run_op(1, 18'h00006, 16'h9876, 2'b10);
        run_op(0, 18'h00006, 16'h0000, 2'b01);

        // random mix
        for (int n = 0; n < 200; n++) begin
            run_op($urandom_range(0, 1), 18'($urandom), 16'($urandom), 2'($urandom));
        end
        for (int n = 0; n < 64; n++) begin
            run_op(0, 18'(n * 16), 16'h0000, 2'b11);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule